// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block produces a periodic wakeup interrupt. It counts one-cycle tick pulses from one of two sources. The first is an always-on internal tick at about 1 kHz that runs independently of the bus clock. The second is a tick derived from an external reference oscillator. Each time the programmed number of ticks has been counted, the block sets a sticky status flag. The flag drives the interrupt output when the local interrupt enable is set.

Software controls the block through a single 8-bit register. In that register, the status flag is read-only and the acknowledge bit is write-only. The same register holds the source select, the interrupt enable and a 3-bit period code. A period code of zero switches the timer off.

A power-mode input limits which source may advance the count during stop. In the deepest stop mode, only the internal tick counts. In the lighter stop mode, the external tick counts only while the oscillator-kept-in-stop input is high.

Top module: `rti_timer`

## Requirements
- R1: After reset, the register reads 0x00 and `irq` is low. This means the internal source is selected, the interrupt is masked and the period code is 0 (timer off).
- R2: With the internal source selected, period codes 1 to 7 set the flag on exactly the 8th, 32nd, 64th, 128th, 256th, 512th and 1024th counted tick respectively, and not one tick earlier. After each elapse the count restarts from zero.
- R3: While the period code (bits 2:0) is 0, ticks never set the flag.
- R4: Bit 5 selects the source: 0 = `tick_int`, 1 = `tick_ext`. Ticks from the unselected source are not counted.
- R5: The flag is read at bit 7 and is sticky. Further ticks leave it set until it is acknowledged.
- R6: Writing a 1 to bit 6 clears the flag. Bit 6 and bit 3 always read back as 0.
- R7: `irq` is high exactly when the flag and the enable bit (bit 4) are both set. Clearing the enable masks `irq` but does not stop the count or the flag.
- R8: When `pwr_mode` is 2 or 3 (deep stop), `tick_ext` is never counted, while `tick_int` still counts and still raises the flag.
- R9: When `pwr_mode` is 1 (light stop), `tick_ext` is counted only while `osc_stop_en` is high. When `pwr_mode` is 0 (run), it is always counted.
- R10: A write that changes the period code or the source select restarts the count from zero. A write that leaves both unchanged does not disturb the count.
- R11: If a period elapses in the same cycle as an acknowledge write, the flag is set after that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data: bit 6 ack, bit 5 source select, bit 4 enable, bits 2:0 period code |
| rd_data | output | 8 | Register read: bit 7 flag, bits 5, 4, 2:0 as written, others 0 |
| tick_int | input | 1 | Internal low-frequency tick, one-cycle pulse |
| tick_ext | input | 1 | External reference tick, one-cycle pulse |
| pwr_mode | input | 2 | 0 run, 1 light stop, 2 or 3 deep stop |
| osc_stop_en | input | 1 | External oscillator kept running in light stop |
| irq | output | 1 | Interrupt request |

## Verification
A tick or write that is sampled at one rising edge shows its result in `rd_data` and `irq` immediately after that edge. There is no further pipeline stage, because both outputs decode registers directly. Every stimulus, whether a tick pulse or a write strobe, is driven for exactly one cycle starting at a falling edge. It is removed at the next falling edge, and the outputs are read at that same falling edge. A wrong result therefore shows up as a wrong value at that exact sample. Off-by-one period errors are caught by checking that the flag is still clear after N-1 ticks and set after the Nth tick.

// File: rtl/rti_pkg.sv
package rti_pkg;

  localparam int DATA_W   = 8;
  localparam int CODE_W   = 3;
  localparam int CNT_W    = 10;

  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int SEL_BIT  = 5;
  localparam int IE_BIT   = 4;
  localparam int CODE_LSB = 0;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_LIGHT = 2'd1;

  typedef struct packed {
    logic              clk_sel;
    logic              irq_en;
    logic [CODE_W-1:0] code;
  } rti_cfg_t;

  // Number of ticks per period for a given code; 0 means the timer is off.
  function automatic int period_ticks(logic [CODE_W-1:0] code);
    int n;
    if (code == '0)        n = 0;
    else if (code == 3'd1) n = 8;
    else                   n = 1 << (int'(code) + 3);
    return n;
  endfunction

endpackage

// File: rtl/rti_tick_sel.sv
module rti_tick_sel (
  input  logic       tick_int,
  input  logic       tick_ext,
  input  logic       clk_sel,
  input  logic [1:0] pwr_mode,
  input  logic       osc_stop_en,
  output logic       tick
);
  import rti_pkg::*;

  logic ext_allowed;

  always_comb begin
    ext_allowed = (pwr_mode == MODE_RUN) ||
                  ((pwr_mode == MODE_LIGHT) && osc_stop_en);
    if (clk_sel) tick = tick_ext && ext_allowed;
    else         tick = tick_int;
  end

endmodule

// File: rtl/rti_counter.sv
module rti_counter #(
  parameter int CNT_W  = rti_pkg::CNT_W,
  parameter int CODE_W = rti_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              elapse
);
  import rti_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, term;
  logic             cnt_en;

  always_comb begin
    term   = CNT_W'(period_ticks(code) - 1);
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    elapse = 1'b0;
    if (restart || code == '0) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (cnt_q >= term) begin
        cnt_d  = '0;
        elapse = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count never passes the terminal value of the current code
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> (cnt_q <= term));

  // R3: a disabled timer holds its count at zero
  a_r3_off_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> (cnt_q == '0));

  // R10: a reconfiguration restarts the count
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/rti_ctrl_reg.sv
module rti_ctrl_reg #(
  parameter int DATA_W = rti_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              elapse,
  output rti_pkg::rti_cfg_t cfg,
  output logic              flag,
  output logic              restart,
  output logic [DATA_W-1:0] rd_data
);
  import rti_pkg::*;

  rti_cfg_t cfg_q, cfg_d, wr_cfg;
  logic     flag_q, flag_d, ack;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[FLAG_BIT], wr_data[3], wr_data[DATA_W-1:FLAG_BIT]};

  always_comb begin
    wr_cfg.clk_sel = wr_data[SEL_BIT];
    wr_cfg.irq_en  = wr_data[IE_BIT];
    wr_cfg.code    = wr_data[CODE_LSB +: CODE_W];
    ack     = wr_en && wr_data[ACK_BIT];
    restart = wr_en && ((wr_cfg.clk_sel != cfg_q.clk_sel) ||
                        (wr_cfg.code    != cfg_q.code));
    cfg_d   = wr_en ? wr_cfg : cfg_q;
    flag_d  = elapse || (flag_q && !ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[FLAG_BIT] = flag_q;
    rd_data[SEL_BIT]  = cfg_q.clk_sel;
    rd_data[IE_BIT]   = cfg_q.irq_en;
    rd_data[CODE_LSB +: CODE_W] = cfg_q.code;
  end

  assign cfg  = cfg_q;
  assign flag = flag_q;

  // R11: an elapse always leaves the flag set, even under acknowledge
  a_r11_elapse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    elapse |=> flag_q);

  // R6: an acknowledge without a coincident elapse clears the flag
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !elapse) |=> !flag_q);

  // R5: the flag only drops through an acknowledge
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q);

endmodule

// File: rtl/rti_timer.sv
module rti_timer #(
  parameter int DATA_W = rti_pkg::DATA_W,
  parameter int CNT_W  = rti_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_int,
  input  logic              tick_ext,
  input  logic [1:0]        pwr_mode,
  input  logic              osc_stop_en,
  output logic              irq
);
  import rti_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  rti_cfg_t   cfg;
  logic       flag, restart, elapse, tick_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  rti_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .elapse  (elapse),
    .cfg     (cfg),
    .flag    (flag),
    .restart (restart),
    .rd_data (rd_data)
  );

  rti_tick_sel u_sel (
    .tick_int    (tick_int),
    .tick_ext    (tick_ext),
    .clk_sel     (cfg.clk_sel),
    .pwr_mode    (pwr_mode),
    .osc_stop_en (osc_stop_en),
    .tick        (tick_sel)
  );

  rti_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_sel),
    .restart (restart),
    .code    (cfg.code),
    .elapse  (elapse)
  );

  assign irq = flag && cfg.irq_en;

  // R8: in deep stop the external source never advances the count
  a_r8_deep_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pwr_mode[1] && cfg.clk_sel) |-> !tick_sel);

  // R4: with the external source chosen, internal ticks are not counted
  a_r4_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg.clk_sel && !tick_ext) |-> !tick_sel);

endmodule

// File: tb/rti_timer_bench.sv
module rti_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tick_int, tick_ext;
  logic [1:0] pwr_mode;
  logic       osc_stop_en;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rti_timer u_rti_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick_int(tick_int), .tick_ext(tick_ext),
    .pwr_mode(pwr_mode), .osc_stop_en(osc_stop_en), .irq(irq)
  );

  // {period code, expected tick count}
  localparam logic [13:0] VEC [7] = '{
    {3'd1, 11'd8},   {3'd2, 11'd32},  {3'd3, 11'd64},  {3'd4, 11'd128},
    {3'd5, 11'd256}, {3'd6, 11'd512}, {3'd7, 11'd1024}
  };

  function automatic logic [7:0] cfgb(bit ack, bit sel, bit ie, logic [2:0] code);
    return {1'b0, ack, sel, ie, 1'b0, code};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(int n, bit ext);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (ext) tick_ext = 1'b1; else tick_int = 1'b1;
      @(negedge clk); tick_ext = 1'b0; tick_int = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick_int = 1'b0;
    tick_ext = 1'b0; pwr_mode = 2'd0; osc_stop_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release rd_data", rd_data, 8'h00);

    // R3: code 0 stays quiet
    wr(cfgb(0, 0, 1, 3'd0));
    ticks(40, 0);
    check("R3 off no flag", rd_data[7], 1'b0);
    check("R3 off no irq", irq, 1'b0);

    // R2: table of period codes
    for (int v = 0; v < 7; v++) begin
      logic [2:0] code;
      int n;
      code = VEC[v][13:11];
      n    = int'(VEC[v][10:0]);
      wr(cfgb(1, 0, 1, code));
      ticks(n - 1, 0);
      check($sformatf("R2 code %0d not early", code), rd_data[7], 1'b0);
      ticks(1, 0);
      check($sformatf("R2 code %0d flag", code), rd_data[7], 1'b1);
      check($sformatf("R7 code %0d irq", code), irq, 1'b1);
      check($sformatf("R6 code %0d readback", code), rd_data, {5'b10010, code});
    end

    // R5: sticky under further ticks
    ticks(3, 0);
    check("R5 flag sticky", rd_data[7], 1'b1);

    // R6: acknowledge clears
    wr(cfgb(1, 0, 1, 3'd7));
    check("R6 ack clears", rd_data, 8'h17);
    check("R6 irq low after ack", irq, 1'b0);

    // R7: masked interrupt, timer still runs
    wr(cfgb(0, 0, 0, 3'd1));
    ticks(8, 0);
    check("R7 flag while masked", rd_data[7], 1'b1);
    check("R7 irq masked", irq, 1'b0);
    wr(cfgb(0, 0, 1, 3'd1));
    check("R7 irq on enable", irq, 1'b1);

    // R4: external source selected
    wr(cfgb(1, 1, 1, 3'd1));
    ticks(8, 0);
    check("R4 internal ignored", rd_data[7], 1'b0);
    ticks(8, 1);
    check("R4 external counted", rd_data[7], 1'b1);

    // R8: deep stop
    wr(cfgb(1, 1, 1, 3'd1));
    pwr_mode = 2'd2;
    ticks(8, 1);
    check("R8 ext blocked flag", rd_data[7], 1'b0);
    check("R8 ext blocked irq", irq, 1'b0);
    pwr_mode = 2'd3;
    ticks(8, 1);
    check("R8 mode3 ext blocked", rd_data[7], 1'b0);
    wr(cfgb(0, 0, 1, 3'd1));
    ticks(8, 0);
    check("R8 internal in deep", rd_data[7], 1'b1);
    pwr_mode = 2'd0;

    // R9: light stop
    wr(cfgb(1, 1, 1, 3'd1));
    pwr_mode = 2'd1; osc_stop_en = 1'b0;
    ticks(8, 1);
    check("R9 light osc off", rd_data[7], 1'b0);
    osc_stop_en = 1'b1;
    ticks(8, 1);
    check("R9 light osc on", rd_data[7], 1'b1);
    pwr_mode = 2'd0; osc_stop_en = 1'b0;

    // R10: restart only on a change
    wr(cfgb(1, 0, 1, 3'd1));
    ticks(5, 0);
    wr(cfgb(0, 0, 1, 3'd1));
    ticks(3, 0);
    check("R10 same config keeps count", rd_data[7], 1'b1);
    wr(cfgb(1, 0, 1, 3'd1));
    ticks(5, 0);
    wr(cfgb(0, 0, 1, 3'd2));
    ticks(27, 0);
    check("R10 new code restarts", rd_data[7], 1'b0);
    ticks(5, 0);
    check("R10 full period after restart", rd_data[7], 1'b1);

    // R11: elapse and acknowledge in one cycle
    wr(cfgb(1, 0, 1, 3'd1));
    ticks(7, 0);
    check("R11 before last tick", rd_data[7], 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_data = cfgb(1, 0, 1, 3'd1); tick_int = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; tick_int = 1'b0;
    check("R11 flag kept", rd_data[7], 1'b1);
    wr(cfgb(1, 0, 1, 3'd1));
    check("R6 later ack clears", rd_data[7], 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule